// File: doc/BRIEF.md
# Paged Register File Addressing Unit

This block is an 8-bit register file with 256 direct register addresses. The top address group is a 16-register window into one of up to 64 peripheral pages. A register address has two nibbles. The upper nibble picks one of sixteen groups of sixteen registers, and the lower nibble picks the register inside that group. Groups 0 to D hold 224 general-purpose registers. Group E holds the system registers: the port data registers, the register pointer, the page pointer and the stack and mode bytes. Group F is the paged window.

Each of the two access ports has a mode select. In full mode the 8-bit address is used as given. In working mode only the low nibble of the supplied address is used, and the register pointer supplies the upper nibble. The write port is synchronous and the read port is combinational. The page pointer selects which page the window shows, and it stays in effect until software rewrites it. A mask parameter marks which pages have a peripheral behind them. The block exposes the page pointer, the six port data bytes, and a one-hot strobe that tells the selected peripheral page it was written.

Top module: `paged_regfile`

## Requirements
- R1: A full-mode write to any address 0x00–0xDF stores the byte, and a full-mode read of the same address returns it from the next cycle onward.
- R2: In working mode the resolved address is {bits 7:4 of the register pointer at 0xE9, bits 3:0 of the supplied address}. The upper four bits of the supplied address and the low nibble of the pointer are ignored. The resolved address may land in any group, including the system group.
- R3: System registers 0xE0–0xE5 are the data bytes of ports 0 to 5. Port k appears on port_data bits [8k+7:8k].
- R4: A full-mode access to 0xF0–0xFF reaches register (address bits 3:0) of the page named by the page pointer at 0xEA. Different pages keep separate contents. The pointer persists across any number of accesses until it is rewritten.
- R5: The page pointer holds 6 bits. A write to 0xEA stores bits 5:0 and ignores bits 7:6. Reading 0xEA returns {2'b00, pointer}, and page_ptr shows the pointer one cycle after the write.
- R6: A page whose bit is clear in PAGE_PRESENT reads 0xFF at every window address, and writes to it change no stored value.
- R7: During a write into the window, page_wr_stb has exactly bit (page pointer) set if that page is present, and is all zero otherwise. It is zero whenever no window write is taking place.
- R8: A read and a write to the same resolved location in the same cycle return the old value. The new value is read from the next cycle.
- R9: Synchronous active-high reset clears the whole system group, including the page pointer and the register pointer, to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_work | input | 1 | Write address mode: 1 = working (pointer-relative), 0 = full |
| wr_addr | input | 8 | Write register address |
| wr_data | input | 8 | Write data |
| rd_work | input | 1 | Read address mode: 1 = working, 0 = full |
| rd_addr | input | 8 | Read register address |
| rd_data | output | 8 | Combinational read data |
| page_ptr | output | 6 | Current page pointer |
| port_data | output | 48 | Port 0–5 data registers, port k in bits [8k+7:8k] |
| page_wr_stb | output | 64 | One-hot write strobe per peripheral page |

## Verification
The hardest case to reach is a working-mode write whose resolved address falls inside the system group and changes a pointer. A write of that kind changes how every later access resolves. The stimulus sets the register pointer to a group-E value with a stray low nibble, then issues a working-mode write of register 0xA. It then observes the new page on page_ptr and through window reads. Absent pages are exercised with a write followed by reads of both the absent page and a present page that shares the window offset. This shows that the ignored write reached no storage.

// File: rtl/pr_pkg.sv
package pr_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int NIB_W    = ADDR_W / 2;
    localparam int GRP_REGS = 1 << NIB_W;
    localparam logic [NIB_W-1:0] SYS_GRP  = 4'hE;
    localparam logic [NIB_W-1:0] WIN_GRP  = 4'hF;
    localparam logic [NIB_W-1:0] RP_SLOT  = 4'h9;
    localparam logic [NIB_W-1:0] PP_SLOT  = 4'hA;
    localparam int PORT_CNT = 6;

    typedef enum logic [1:0] {
        RG_GP   = 2'd0,
        RG_SYS  = 2'd1,
        RG_WIN  = 2'd2
    } region_e;

    typedef struct packed {
        region_e           region;
        logic [ADDR_W-1:0] addr;
    } loc_t;
endpackage

// File: rtl/pr_resolve.sv
module pr_resolve
    import pr_pkg::*;
(
    input  logic              work,
    input  logic [ADDR_W-1:0] raw,
    input  logic [ADDR_W-1:0] rp,
    output loc_t              loc
);
    logic [ADDR_W-1:0] full;

    always_comb begin
        full = work ? {rp[ADDR_W-1:NIB_W], raw[NIB_W-1:0]} : raw;
        loc.addr = full;
        if (full[ADDR_W-1:NIB_W] == WIN_GRP)
            loc.region = RG_WIN;
        else if (full[ADDR_W-1:NIB_W] == SYS_GRP)
            loc.region = RG_SYS;
        else
            loc.region = RG_GP;
    end
endmodule

// File: rtl/pr_sys_group.sv
module pr_sys_group
    import pr_pkg::*;
#(
    parameter int PG_W = 6
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [NIB_W-1:0]           widx,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NIB_W-1:0]           ridx,
    output logic [DATA_W-1:0]          rdata,
    output logic [ADDR_W-1:0]          rp,
    output logic [PG_W-1:0]            pp,
    output logic [PORT_CNT*DATA_W-1:0] ports
);
    typedef struct packed {
        logic [GRP_REGS-1:0][DATA_W-1:0] regs;
    } sys_t;

    sys_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (widx == PP_SLOT)
                st_d.regs[widx] = {{(DATA_W-PG_W){1'b0}}, wdata[PG_W-1:0]};
            else
                st_d.regs[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata = st_q.regs[ridx];
    assign rp    = st_q.regs[RP_SLOT];
    assign pp    = st_q.regs[PP_SLOT][PG_W-1:0];

    for (genvar k = 0; k < PORT_CNT; k++) begin : g_port
        assign ports[k*DATA_W +: DATA_W] = st_q.regs[k];
    end
endmodule

// File: rtl/pr_page_bank.sv
module pr_page_bank
    import pr_pkg::*;
#(
    parameter int                PAGES   = 64,
    parameter logic [PAGES-1:0]  PRESENT = '1,
    localparam int               PG_W    = $clog2(PAGES)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PG_W-1:0]   wpage,
    input  logic [NIB_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PG_W-1:0]   rpage,
    input  logic [NIB_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic [PAGES-1:0]  wr_stb
);
    logic [PAGES-1:0][DATA_W-1:0] word;

    for (genvar g = 0; g < PAGES; g++) begin : g_page
        if (PRESENT[g]) begin : g_real
            logic [GRP_REGS-1:0][DATA_W-1:0] mem_d, mem_q;
            logic hit;
            assign hit = we && (wpage == PG_W'(g));
            always_comb begin
                mem_d = mem_q;
                if (hit) mem_d[widx] = wdata;
            end
            always_ff @(posedge clk) mem_q <= mem_d;
            assign word[g]   = mem_q[ridx];
            assign wr_stb[g] = hit;
        end else begin : g_void
            assign word[g]   = '1;
            assign wr_stb[g] = 1'b0;
        end
    end

    assign rdata = word[rpage];

    a_r7_stb_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));
    a_r7_stb_quiet: assert property (@(posedge clk) disable iff (rst)
        !we |-> (wr_stb == '0));
    a_r6_void_reads_ones: assert property (@(posedge clk) disable iff (rst)
        !PRESENT[rpage] |-> (rdata == '1));
endmodule

// File: rtl/paged_regfile.sv
module paged_regfile
    import pr_pkg::*;
#(
    parameter int               PAGES        = 64,
    parameter logic [PAGES-1:0] PAGE_PRESENT = 64'h0000_0000_0000_082D,
    localparam int              PG_W         = $clog2(PAGES),
    localparam int              GP_CNT       = int'(SYS_GRP) * GRP_REGS
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       wr_work,
    input  logic [7:0]                 wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic                       rd_work,
    input  logic [7:0]                 rd_addr,
    output logic [7:0]                 rd_data,
    output logic [5:0]                 page_ptr,
    output logic [47:0]                port_data,
    output logic [63:0]                page_wr_stb
);
    loc_t              wr_loc, rd_loc;
    logic [ADDR_W-1:0] rp;
    logic [PG_W-1:0]   pp;
    logic [DATA_W-1:0] sys_rdata, win_rdata, gp_rdata;

    logic [GP_CNT-1:0][DATA_W-1:0] gp_d, gp_q;

    pr_resolve u_wr_res (.work(wr_work), .raw(wr_addr), .rp(rp), .loc(wr_loc));
    pr_resolve u_rd_res (.work(rd_work), .raw(rd_addr), .rp(rp), .loc(rd_loc));

    pr_sys_group #(.PG_W(PG_W)) u_sys (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && wr_loc.region == RG_SYS),
        .widx  (wr_loc.addr[NIB_W-1:0]),
        .wdata (wr_data),
        .ridx  (rd_loc.addr[NIB_W-1:0]),
        .rdata (sys_rdata),
        .rp    (rp),
        .pp    (pp),
        .ports (port_data)
    );

    pr_page_bank #(.PAGES(PAGES), .PRESENT(PAGE_PRESENT)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en && wr_loc.region == RG_WIN),
        .wpage  (pp),
        .widx   (wr_loc.addr[NIB_W-1:0]),
        .wdata  (wr_data),
        .rpage  (pp),
        .ridx   (rd_loc.addr[NIB_W-1:0]),
        .rdata  (win_rdata),
        .wr_stb (page_wr_stb)
    );

    always_comb begin
        gp_d = gp_q;
        if (wr_en && wr_loc.region == RG_GP)
            gp_d[wr_loc.addr] = wr_data;
    end

    always_ff @(posedge clk) gp_q <= gp_d;

    assign gp_rdata = (rd_loc.region == RG_GP) ? gp_q[rd_loc.addr] : '0;

    always_comb begin
        unique case (rd_loc.region)
            RG_SYS:  rd_data = sys_rdata;
            RG_WIN:  rd_data = win_rdata;
            default: rd_data = gp_rdata;
        endcase
    end

    assign page_ptr = pp;

    a_r5_pp_takes_low_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_loc.addr == {SYS_GRP, PP_SLOT}) |=> (page_ptr == $past(wr_data[5:0])));
    a_r5_pp_holds: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_loc.addr == {SYS_GRP, PP_SLOT}) |=> $stable(page_ptr));
    a_r9_reset_clears_pp: assert property (@(posedge clk)
        rst |=> (page_ptr == '0));
endmodule

// File: tb/paged_regfile_test.sv
module paged_regfile_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_work = 1'b0, rd_work = 1'b0;
    logic [7:0]  wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0]  rd_data;
    logic [5:0]  page_ptr;
    logic [47:0] port_data;
    logic [63:0] page_wr_stb;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    paged_regfile uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_work(wr_work),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_work(rd_work),
        .rd_addr(rd_addr), .rd_data(rd_data), .page_ptr(page_ptr),
        .port_data(port_data), .page_wr_stb(page_wr_stb)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic work, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_work = work; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_work = 1'b0;
    endtask

    task automatic rd(input logic work, input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_work = work; rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        wr(1'b0, 8'hEA, 8'h05);
        wr(1'b0, 8'hE9, 8'h30);
        wr(1'b0, 8'hE2, 8'h99);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(1'b0, 8'hEA, v); check("R9 page pointer cleared", v, 8'h00);
        rd(1'b0, 8'hE9, v); check("R9 register pointer cleared", v, 8'h00);
        check("R9 page_ptr output", page_ptr, 6'd0);
        check("R9 ports cleared", port_data, 48'h0);
    endtask

    task automatic t_general;
        logic [7:0] v;
        wr(1'b0, 8'h00, 8'hA5);
        wr(1'b0, 8'hDF, 8'h3C);
        wr(1'b0, 8'h7B, 8'h11);
        rd(1'b0, 8'h00, v); check("R1 lowest gp", v, 8'hA5);
        rd(1'b0, 8'hDF, v); check("R1 highest gp", v, 8'h3C);
        rd(1'b0, 8'h7B, v); check("R1 middle gp", v, 8'h11);
    endtask

    task automatic t_working;
        logic [7:0] v;
        wr(1'b0, 8'hE9, 8'h5C);
        wr(1'b1, 8'hA3, 8'h77);
        rd(1'b0, 8'h53, v); check("R2 working write lands at 0x53", v, 8'h77);
        rd(1'b1, 8'h03, v); check("R2 working read", v, 8'h77);
        wr(1'b0, 8'hE9, 8'hE7);
        wr(1'b1, 8'h0A, 8'h02);
        @(negedge clk);
        check("R2 working write into system group sets page", page_ptr, 6'd2);
        rd(1'b1, 8'h09, v); check("R2 working read of pointer itself", v, 8'hE7);
        wr(1'b0, 8'hEA, 8'h00);
    endtask

    task automatic t_ports;
        for (int k = 0; k < 6; k++) wr(1'b0, 8'hE0 + 8'(k), 8'h10 + 8'(k));
        @(negedge clk);
        check("R3 port data bytes", port_data, 48'h15_14_13_12_11_10);
    endtask

    task automatic t_pages;
        logic [7:0] v;
        wr(1'b0, 8'hEA, 8'h00);
        wr(1'b0, 8'hF4, 8'h40);
        wr(1'b0, 8'hEA, 8'h02);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'hF4; wr_data = 8'h42;
        #1 check("R7 strobe for page 2", page_wr_stb, 64'h4);
        @(negedge clk); wr_en = 1'b0;
        wr(1'b0, 8'hF5, 8'h52);
        rd(1'b0, 8'hF4, v); check("R4 page 2 offset 4", v, 8'h42);
        rd(1'b0, 8'hF5, v); check("R4 page 2 persists", v, 8'h52);
        wr(1'b0, 8'hEA, 8'h00);
        rd(1'b0, 8'hF4, v); check("R4 page 0 kept separate", v, 8'h40);
        check("R7 strobe idle", page_wr_stb, 64'h0);
    endtask

    task automatic t_ptr_mask;
        logic [7:0] v;
        wr(1'b0, 8'hEA, 8'hC5);
        @(negedge clk);
        check("R5 page_ptr upper bits dropped", page_ptr, 6'd5);
        rd(1'b0, 8'hEA, v); check("R5 pointer read back", v, 8'h05);
    endtask

    task automatic t_absent;
        logic [7:0] v;
        wr(1'b0, 8'hEA, 8'h00);
        wr(1'b0, 8'hF0, 8'h5A);
        wr(1'b0, 8'hEA, 8'h01);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'hF0; wr_data = 8'h12;
        #1 check("R7 no strobe for absent page", page_wr_stb, 64'h0);
        @(negedge clk); wr_en = 1'b0;
        rd(1'b0, 8'hF0, v); check("R6 absent page reads ones", v, 8'hFF);
        wr(1'b0, 8'hEA, 8'h3F);
        rd(1'b0, 8'hF7, v); check("R6 page 63 absent", v, 8'hFF);
        wr(1'b0, 8'hEA, 8'h00);
        rd(1'b0, 8'hF0, v); check("R6 ignored write left page 0", v, 8'h5A);
    endtask

    task automatic t_same_cycle;
        wr(1'b0, 8'h20, 8'h01);
        @(negedge clk);
        rd_work = 1'b0; rd_addr = 8'h20;
        wr_en = 1'b1; wr_addr = 8'h20; wr_data = 8'h02;
        #1 check("R8 old value in write cycle", rd_data, 8'h01);
        @(negedge clk); wr_en = 1'b0;
        #1 check("R8 new value next cycle", rd_data, 8'h02);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_general();
        t_working();
        t_ports();
        t_pages();
        t_ptr_mask();
        t_absent();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule